// File: doc/BRIEF.md
# On-Deck Predicated Loop Executor

This block is the last stage of an instruction queue. It pulls one instruction at a time from the head of the instruction FIFO into an on-deck register. It then settles two matters in one evaluation cycle: whether a copy of the instruction goes back into the queue, and whether the instruction runs. The block owns the outer loop counter, the inner loop counter and two condition flags, A and B. Each instruction carries a 3-bit predicate that tests the outer counter and the flags.

A torpedo is an asynchronous cancel request. It arrives as a pulse on a dedicated pin or as a token word at the instruction port. It waits until an interruptible move instruction whose predicate holds comes on deck. That move is then cancelled: the outer counter is cleared and the inner counter is forced to one. The data movement is not modelled here. A one-cycle execute strobe stands in for it. The counter values are exposed for the datapath, and an outer-loop-zero level goes to the hatch logic upstream.

Top module: `od_exec`

## Requirements
- R1: Instruction word (16 bits): kind in [15:14] (0 move, 1 set, 2 shift, 3 torpedo token), one-shot in [13], interruptible in [12], predicate in [11:9], set operation in [8:6], immediate in [5:0].
- R2: Predicate codes: 000 outer≠0 and A=0; 001 outer≠0 and A=1; 010 outer≠0 and B=0; 011 outer≠0 and B=1; 100 never; 101 outer=0; 110 outer≠0; 111 always.
- R3: An instruction whose predicate is false has no effect on the counters, the flags or the execute strobe.
- R4: An executed instruction drives `exec_o` high for exactly one cycle, two cycles after it is accepted.
- R5: Set operations: 1 loads the outer counter from the immediate; 2 decrements the outer counter, which saturates at 0; 3 loads the inner counter from the immediate; 4 sets A from imm[0] and B from imm[1]; all other codes change nothing.
- R6: A copy is requeued only when the instruction is not one-shot and the outer counter was nonzero before this instruction executed. The copy is offered on `rq_instr_o` with `rq_valid_o`.
- R7: When the predicate is true, the instruction is an interruptible move and a torpedo is waiting, the torpedo is consumed, the outer counter becomes 0, the inner counter becomes 1, and no execute strobe is given.
- R8: Set and shift instructions, and moves with the interruptible bit clear, never consume a torpedo, even when bit [12] is set.
- R9: A token word (kind 3) accepted at the instruction port leaves a torpedo waiting. It neither executes nor requeues.
- R10: No new instruction is accepted until the requeue copy, if any, has been taken. While `rq_valid_o` is high and `rq_ready_i` is low, the copy stays stable.
- R11: After reset both counters and both flags are 0, no torpedo waits, `exec_o` and `rq_valid_o` are low, and `in_ready_o` is high.
- R12: `olc_zero_o` is high exactly when the outer counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Instruction FIFO head is valid |
| in_instr_i | input | 16 | Instruction word at the FIFO head |
| in_ready_o | output | 1 | On-deck register is free; the head is taken |
| torp_i | input | 1 | Torpedo pulse |
| rq_valid_o | output | 1 | Requeue copy offered |
| rq_instr_o | output | 16 | Requeued instruction copy |
| rq_ready_i | input | 1 | Queue accepts the requeue copy |
| exec_o | output | 1 | One-cycle execute strobe to the datapath |
| olc_o | output | 6 | Outer loop counter |
| ilc_o | output | 6 | Inner loop counter |
| olc_zero_o | output | 1 | Outer loop counter equals zero |

## Verification
Requeue and torpedo cancellation can fall in the same evaluation cycle. A requeueable, interruptible move with a true predicate meets a waiting torpedo while the outer counter is nonzero. The bench provokes this by loading the outer counter to 7, pulsing `torp_i`, and then issuing such a move. It judges the result from the outputs: the copy must still be offered, because the decision uses the counter value from before the cancel. At the same time the outer counter must read 0, the inner counter 1, and no strobe may appear.

// File: rtl/od_pkg.sv
package od_pkg;
    localparam int CNT_W   = 6;
    localparam int PRED_W  = 3;
    localparam int OP_W    = 3;
    localparam int INSTR_W = 2 + 1 + 1 + PRED_W + OP_W + CNT_W;

    typedef enum logic [1:0] {
        K_MOVE  = 2'd0,
        K_SET   = 2'd1,
        K_SHIFT = 2'd2,
        K_TOKEN = 2'd3
    } kind_e;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 3'd0,
        OP_OLC_LD  = 3'd1,
        OP_OLC_DEC = 3'd2,
        OP_ILC_LD  = 3'd3,
        OP_FLAGS   = 3'd4
    } setop_e;

    typedef struct packed {
        kind_e              kind;
        logic               one_shot;
        logic               intr;
        logic [PRED_W-1:0]  pred;
        logic [OP_W-1:0]    op;
        logic [CNT_W-1:0]   imm;
    } instr_t;
endpackage

// File: rtl/od_pred.sv
module od_pred
    import od_pkg::*;
(
    input  logic [PRED_W-1:0] pred_i,
    input  logic              olc_nz_i,
    input  logic              flag_a_i,
    input  logic              flag_b_i,
    output logic              hit_o
);
    always_comb begin
        case (pred_i)
            3'b000:  hit_o = olc_nz_i & ~flag_a_i;
            3'b001:  hit_o = olc_nz_i &  flag_a_i;
            3'b010:  hit_o = olc_nz_i & ~flag_b_i;
            3'b011:  hit_o = olc_nz_i &  flag_b_i;
            3'b101:  hit_o = ~olc_nz_i;
            3'b110:  hit_o = olc_nz_i;
            3'b111:  hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

    // R2
    always_comb begin
        never_hit_chk: assert (!(pred_i == 3'b100 && hit_o));
    end
endmodule

// File: rtl/od_torp.sv
module od_torp (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive_i,
    input  logic consume_i,
    output logic pending_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = (pend_q & ~consume_i) | arrive_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending_o = pend_q;

    // R7
    consume_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |-> pending_o);
    // R9
    arrive_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arrive_i |=> pending_o);
endmodule

// File: rtl/od_exec.sv
module od_exec
    import od_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [INSTR_W-1:0] in_instr_i,
    output logic               in_ready_o,
    input  logic               torp_i,
    output logic               rq_valid_o,
    output logic [INSTR_W-1:0] rq_instr_o,
    input  logic               rq_ready_i,
    output logic               exec_o,
    output logic [CNT_W-1:0]   olc_o,
    output logic [CNT_W-1:0]   ilc_o,
    output logic               olc_zero_o
);
    typedef struct packed {
        logic             od_v;
        logic             wait_ph;
        instr_t           od;
        logic [CNT_W-1:0] olc;
        logic [CNT_W-1:0] ilc;
        logic             fa;
        logic             fb;
        logic             exec;
        logic             rq;
    } st_t;

    st_t  s_d, s_q;
    logic hit, torp_pend, take_torp, tok_arrive, eval_ph, olc_nz;

    assign olc_nz  = (s_q.olc != '0);
    assign eval_ph = s_q.od_v & ~s_q.wait_ph;

    od_pred u_pred (
        .pred_i   (s_q.od.pred),
        .olc_nz_i (olc_nz),
        .flag_a_i (s_q.fa),
        .flag_b_i (s_q.fb),
        .hit_o    (hit)
    );

    assign take_torp  = eval_ph & (s_q.od.kind == K_MOVE) & s_q.od.intr & hit & torp_pend;
    assign tok_arrive = eval_ph & (s_q.od.kind == K_TOKEN);

    od_torp u_torp (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (torp_i | tok_arrive),
        .consume_i (take_torp),
        .pending_o (torp_pend)
    );

    always_comb begin
        s_d      = s_q;
        s_d.exec = 1'b0;
        if (!s_q.od_v) begin
            if (in_valid_i) begin
                s_d.od_v    = 1'b1;
                s_d.wait_ph = 1'b0;
                s_d.od      = instr_t'(in_instr_i);
            end
        end else if (!s_q.wait_ph) begin
            s_d.wait_ph = 1'b1;
            if (s_q.od.kind != K_TOKEN) begin
                s_d.rq = ~s_q.od.one_shot & olc_nz;
                if (hit) begin
                    if (take_torp) begin
                        s_d.olc = '0;
                        s_d.ilc = CNT_W'(1);
                    end else begin
                        s_d.exec = 1'b1;
                        if (s_q.od.kind == K_SET) begin
                            case (s_q.od.op)
                                OP_OLC_LD:  s_d.olc = s_q.od.imm;
                                OP_OLC_DEC: s_d.olc = olc_nz ? s_q.olc - CNT_W'(1) : '0;
                                OP_ILC_LD:  s_d.ilc = s_q.od.imm;
                                OP_FLAGS: begin
                                    s_d.fa = s_q.od.imm[0];
                                    s_d.fb = s_q.od.imm[1];
                                end
                                default: ;
                            endcase
                        end
                    end
                end
            end
        end else if (!s_q.rq || rq_ready_i) begin
            s_d.rq   = 1'b0;
            s_d.od_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready_o = ~s_q.od_v;
    assign rq_valid_o = s_q.rq;
    assign rq_instr_o = s_q.od;
    assign exec_o     = s_q.exec;
    assign olc_o      = s_q.olc;
    assign ilc_o      = s_q.ilc;
    assign olc_zero_o = ~olc_nz;

    // R4
    exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |=> !exec_o);
    // R10
    rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid_o && !rq_ready_i) |=> (rq_valid_o && $stable(rq_instr_o)));
    // R10
    no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid_o |-> !in_ready_o);
    // R7
    torp_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_torp |=> (olc_o == '0 && ilc_o == CNT_W'(1) && !exec_o));
    // R3
    false_pred_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_ph && !hit) |=> (!exec_o && $stable(olc_o) && $stable(ilc_o)));
endmodule

// File: tb/od_exec_tb_top.sv
module od_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid_i;
    logic [15:0] in_instr_i;
    logic        in_ready_o;
    logic        torp_i;
    logic        rq_valid_o;
    logic [15:0] rq_instr_o;
    logic        rq_ready_i;
    logic        exec_o;
    logic [5:0]  olc_o, ilc_o;
    logic        olc_zero_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    od_exec dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_instr_i(in_instr_i),
        .in_ready_o(in_ready_o), .torp_i(torp_i), .rq_valid_o(rq_valid_o),
        .rq_instr_o(rq_instr_o), .rq_ready_i(rq_ready_i), .exec_o(exec_o),
        .olc_o(olc_o), .ilc_o(ilc_o), .olc_zero_o(olc_zero_o)
    );

    // entry: kind2 os intr pred3 op3 imm6 | exec rq olc6 ilc6
    localparam logic [29:0] VEC [17] = '{
        {2'd1,1'b1,1'b0,3'd7,3'd1,6'd5, 1'b1,1'b0,6'd5,6'd0},
        {2'd1,1'b0,1'b0,3'd7,3'd3,6'd3, 1'b1,1'b1,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd0,3'd0,6'd0, 1'b1,1'b0,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd1,3'd0,6'd0, 1'b0,1'b0,6'd5,6'd3},
        {2'd1,1'b1,1'b0,3'd7,3'd4,6'd1, 1'b1,1'b0,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd1,3'd0,6'd0, 1'b1,1'b0,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd2,3'd0,6'd0, 1'b1,1'b0,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd3,3'd0,6'd0, 1'b0,1'b0,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd5,3'd0,6'd0, 1'b0,1'b0,6'd5,6'd3},
        {2'd0,1'b1,1'b0,3'd4,3'd0,6'd0, 1'b0,1'b0,6'd5,6'd3},
        {2'd1,1'b0,1'b0,3'd6,3'd2,6'd0, 1'b1,1'b1,6'd4,6'd3},
        {2'd1,1'b1,1'b0,3'd7,3'd1,6'd1, 1'b1,1'b0,6'd1,6'd3},
        {2'd1,1'b0,1'b0,3'd7,3'd2,6'd0, 1'b1,1'b1,6'd0,6'd3},
        {2'd0,1'b0,1'b0,3'd5,3'd0,6'd0, 1'b1,1'b0,6'd0,6'd3},
        {2'd1,1'b1,1'b0,3'd7,3'd2,6'd0, 1'b1,1'b0,6'd0,6'd3},
        {2'd1,1'b1,1'b0,3'd6,3'd1,6'd9, 1'b0,1'b0,6'd0,6'd3},
        {2'd2,1'b0,1'b0,3'd0,3'd0,6'd0, 1'b0,1'b0,6'd0,6'd3}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] w, input bit e, input bit r,
                         input logic [5:0] o, input logic [5:0] i, input string tag);
        @(negedge clk);
        while (!in_ready_o) @(negedge clk);
        in_valid_i = 1'b1;
        in_instr_i = w;
        @(posedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(exec_o == e, {tag, " R4 exec"}, exec_o, e);
        chk(rq_valid_o == r, {tag, " R6 requeue"}, rq_valid_o, r);
        if (r) chk(rq_instr_o == w, {tag, " R6 copy"}, rq_instr_o, w);
        chk(olc_o == o, {tag, " R5 olc"}, olc_o, o);
        chk(ilc_o == i, {tag, " R5 ilc"}, ilc_o, i);
        chk(olc_zero_o == (o == 0), {tag, " R12 zero"}, olc_zero_o, (o == 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid_i = 1'b0; in_instr_i = '0; torp_i = 1'b0; rq_ready_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(olc_o == 0 && ilc_o == 0, "R11 counters", olc_o, 0);
        chk(olc_zero_o == 1, "R11 R12 zero", olc_zero_o, 1);
        chk(!exec_o && !rq_valid_o, "R11 strobes", exec_o, 0);
        chk(in_ready_o == 1, "R11 ready", in_ready_o, 1);

        // R1 R2 R3 R5 R6 table walk
        for (int k = 0; k < 17; k++) begin
            issue(VEC[k][29:14], VEC[k][13], VEC[k][12], VEC[k][11:6], VEC[k][5:0],
                  $sformatf("R2 R3 vec%0d", k));
        end

        // R7 R8: torpedo waits through non-interruptible work
        issue({2'd1,1'b1,1'b0,3'd7,3'd1,6'd7}, 1, 0, 7, 3, "R5 load7");
        @(negedge clk); torp_i = 1'b1; @(negedge clk); torp_i = 1'b0;
        issue({2'd0,1'b1,1'b0,3'd7,3'd0,6'd0}, 1, 0, 7, 3, "R8 move_noint");
        issue({2'd0,1'b1,1'b1,3'd3,3'd0,6'd0}, 0, 0, 7, 3, "R3 R7 false_pred");
        issue({2'd1,1'b1,1'b1,3'd7,3'd3,6'd2}, 1, 0, 7, 2, "R8 set_intr");
        // R6 R7 requeue and torpedo in the same cycle
        issue({2'd0,1'b0,1'b1,3'd7,3'd0,6'd0}, 0, 1, 0, 1, "R7 R6 concurrent");
        issue({2'd0,1'b1,1'b1,3'd7,3'd0,6'd0}, 1, 0, 0, 1, "R7 consumed_once");

        // R9 token at instruction port
        issue({2'd3,1'b0,1'b0,3'd7,3'd1,6'd9}, 0, 0, 0, 1, "R9 token");
        issue({2'd1,1'b1,1'b0,3'd7,3'd1,6'd3}, 1, 0, 3, 1, "R9 load3");
        issue({2'd1,1'b1,1'b0,3'd7,3'd3,6'd5}, 1, 0, 3, 5, "R9 ilc5");
        issue({2'd0,1'b1,1'b1,3'd7,3'd0,6'd0}, 0, 0, 0, 1, "R9 strike");

        // R10 backpressure on requeue
        issue({2'd1,1'b1,1'b0,3'd7,3'd1,6'd2}, 1, 0, 2, 1, "R10 load2");
        rq_ready_i = 1'b0;
        issue({2'd0,1'b0,1'b0,3'd7,3'd0,6'd0}, 1, 1, 2, 1, "R10 held");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(rq_valid_o == 1, "R10 still valid", rq_valid_o, 1);
            chk(in_ready_o == 0, "R10 blocked", in_ready_o, 0);
            chk(rq_instr_o == {2'd0,1'b0,1'b0,3'd7,3'd0,6'd0}, "R10 stable", rq_instr_o, 0);
            chk(exec_o == 0, "R4 one cycle", exec_o, 0);
        end
        rq_ready_i = 1'b1;
        @(negedge clk);
        chk(rq_valid_o == 0, "R10 taken", rq_valid_o, 0);
        chk(in_ready_o == 1, "R10 freed", in_ready_o, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule